// File: doc/BRIEF.md
# Control Packet Framer for a 64b/66b Line

The block turns a 14-byte payload into a short burst of 66-bit line words, and turns such bursts back into payloads. A packet takes exactly two control-type words. The first is a start block that carries payload bytes 0 to 6. The second is a stop block that carries bytes 7 to 13. Whenever no packet is being sent, the transmitter fills the line with idle blocks, one word on every clock. The payload is offered through a valid/ready handshake. The transmitter will not open a new packet until at least `MIN_GAP` idle words have gone out since the last stop word.

The receive side takes one 66-bit word on every clock. It tracks whether a packet is open and passes over data words (sync `01`) and any other control block found inside a packet. When the stop block arrives, it presents the assembled 14 bytes for one cycle. Three kinds of malformed input raise a one-cycle error pulse: an illegal sync header, a stop block with no open packet, and a start block that arrives while a packet is already open. Scrambling, serialization and clock recovery are handled elsewhere.

Top module: `ctl_pkt_framer`

## Requirements
- R1: After reset, `tx_word` is an idle block (`{2'b10, 8'h1E, 56'h0}`), `in_ready` is 1, and `out_valid` and `rx_err` are 0.
- R2: While no payload is accepted, every word the transmitter sends is an idle block.
- R3: The clock after a payload is accepted (`in_valid && in_ready` at an edge), `tx_word` is `{2'b10, 8'h78, field}`. In the field, payload byte 0 (`in_payload[7:0]`) sits at bits [55:48] and byte 6 sits at bits [7:0].
- R4: The clock after a start word, `tx_word` is `{2'b10, 8'hFF, field}`, with byte 7 at bits [55:48] through byte 13 at bits [7:0]. The bytes are taken from the payload captured when it was accepted, even if `in_payload` has changed since.
- R5: After a stop word, the transmitter sends at least `MIN_GAP` (default 1) idle words before the next start word.
- R6: `in_ready` is 0 from the clock after an accept until the required idle gap has been sent.
- R7: On the receive side, a start block followed by a stop block makes `out_valid` high for one clock after the stop word. `out_payload` then holds the 14 bytes, with byte k at bits [8k+7:8k].
- R8: Inside an open packet, data words (sync `01`) and control blocks of any type other than 0x78 and 0xFF are passed over. They do not change the delivered payload.
- R9: A word whose sync header is `00` or `11` pulses `rx_err` on the next clock and discards any open packet.
- R10: A stop block with no open packet pulses `rx_err` and produces no `out_valid`.
- R11: A start block that arrives while a packet is open pulses `rx_err`. The new start block then opens a fresh packet.
- R12: Idle blocks and data words that arrive outside a packet produce neither `out_valid` nor `rx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A transmit payload is offered |
| in_ready | output | 1 | The transmitter can accept a payload at this edge |
| in_payload | input | 112 | Transmit payload, byte k at [8k+7:8k] |
| tx_word | output | 66 | Outgoing line word, sync header at [65:64] |
| rx_word | input | 66 | Incoming line word, one per clock |
| out_valid | output | 1 | One-cycle strobe for a received payload |
| out_payload | output | 112 | Received payload, byte k at [8k+7:8k] |
| rx_err | output | 1 | One-cycle pulse for a malformed sequence |

## Verification
Every result of this block is registered exactly once. A start word appears on `tx_word` one clock after the accepting edge, and the stop word and the first idle follow on the next two clocks. `out_valid` and `rx_err` rise one clock after the word that causes them. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each check sees the single register stage that follows its stimulus. Transmit timing is then followed word by word through a back-to-back request, to confirm that only one idle separates two packets.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    localparam int SYNC_W    = 2;
    localparam int BLK_W     = 64;
    localparam int LINE_W    = SYNC_W + BLK_W;
    localparam int TYPE_W    = 8;
    localparam int PAY_BYTES = 14;
    localparam int HALF_BYTES = (BLK_W - TYPE_W) / 8;
    localparam int HALF_W    = HALF_BYTES * 8;
    localparam int PAY_W     = PAY_BYTES * 8;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [PAY_W-1:0]  payload_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [TYPE_W-1:0] btype_t;

    localparam logic [SYNC_W-1:0] SYNC_CTL = 2'b10;
    localparam logic [SYNC_W-1:0] SYNC_DAT = 2'b01;
    localparam btype_t TY_START = 8'h78;
    localparam btype_t TY_STOP  = 8'hFF;
    localparam btype_t TY_IDLE  = 8'h1E;

    typedef enum logic [2:0] {
        K_FILL,
        K_START,
        K_STOP,
        K_DATA,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e kind;
        half_t field;
    } word_info_t;

    typedef enum logic [1:0] {
        TX_GAP,
        TX_HEAD,
        TX_TAIL
    } tx_phase_e;

    // Take HALF_BYTES payload bytes from index 'first'; the lowest byte goes to the top of the field
    function automatic half_t pick_half(input payload_t p, input int first);
        half_t h;
        h = '0;
        for (int j = 0; j < HALF_BYTES; j++) begin
            h[HALF_W-1-8*j -: 8] = p[8*(first+j) +: 8];
        end
        return h;
    endfunction

    // Inverse of pick_half: place a field's bytes into payload positions first..first+HALF_BYTES-1
    function automatic payload_t place_half(input payload_t p, input half_t h, input int first);
        payload_t r;
        r = p;
        for (int j = 0; j < HALF_BYTES; j++) begin
            r[8*(first+j) +: 8] = h[HALF_W-1-8*j -: 8];
        end
        return r;
    endfunction

    function automatic line_t make_ctl(input btype_t t, input half_t h);
        return {SYNC_CTL, t, h};
    endfunction

endpackage

// File: rtl/cpf_tx.sv
module cpf_tx
    import cpf_pkg::*;
#(
    parameter int unsigned MIN_GAP = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    input  payload_t in_payload,
    output line_t    tx_word
);

    localparam int GAP_CW = (MIN_GAP < 1) ? 1 : $clog2(MIN_GAP + 1);
    localparam logic [GAP_CW-1:0] GAP_NEED = GAP_CW'(MIN_GAP);

    tx_phase_e         phase;
    logic [GAP_CW-1:0] gap_cnt;
    half_t             tail_r;
    line_t             word_r;
    logic              take;

    assign in_ready = (phase == TX_GAP) && (gap_cnt >= GAP_NEED);
    assign take     = in_valid && in_ready;
    assign tx_word  = word_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= TX_GAP;
            gap_cnt <= GAP_NEED;
            tail_r  <= '0;
            word_r  <= make_ctl(TY_IDLE, '0);
        end else begin
            unique case (phase)
                TX_GAP: begin
                    if (take) begin
                        word_r <= make_ctl(TY_START, pick_half(in_payload, 0));
                        tail_r <= pick_half(in_payload, HALF_BYTES);
                        phase  <= TX_HEAD;
                    end else begin
                        word_r <= make_ctl(TY_IDLE, '0);
                        if (gap_cnt < GAP_NEED) begin
                            gap_cnt <= gap_cnt + GAP_CW'(1);
                        end
                    end
                end
                TX_HEAD: begin
                    word_r <= make_ctl(TY_STOP, tail_r);
                    phase  <= TX_TAIL;
                end
                TX_TAIL: begin
                    word_r  <= make_ctl(TY_IDLE, '0);
                    gap_cnt <= GAP_CW'(1);
                    phase   <= TX_GAP;
                end
                default: phase <= TX_GAP;
            endcase
        end
    end

endmodule

// File: rtl/cpf_classify.sv
module cpf_classify
    import cpf_pkg::*;
(
    input  line_t      word,
    output word_info_t info
);

    logic [SYNC_W-1:0] sync;
    btype_t            btype;

    assign sync  = word[LINE_W-1 -: SYNC_W];
    assign btype = word[BLK_W-1 -: TYPE_W];

    always_comb begin
        info.field = word[HALF_W-1:0];
        if (sync == SYNC_DAT) begin
            info.kind = K_DATA;
        end else if (sync == SYNC_CTL) begin
            if (btype == TY_START) begin
                info.kind = K_START;
            end else if (btype == TY_STOP) begin
                info.kind = K_STOP;
            end else begin
                info.kind = K_FILL;
            end
        end else begin
            info.kind = K_BAD;
        end
    end

endmodule

// File: rtl/cpf_rx.sv
module cpf_rx
    import cpf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  word_info_t info,
    output logic       out_valid,
    output payload_t   out_payload,
    output logic       rx_err
);

    logic     open_r;
    half_t    head_r;
    payload_t pay_r;
    logic     val_r;
    logic     err_r;

    assign out_valid   = val_r;
    assign out_payload = pay_r;
    assign rx_err      = err_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_r <= 1'b0;
            head_r <= '0;
            pay_r  <= '0;
            val_r  <= 1'b0;
            err_r  <= 1'b0;
        end else begin
            val_r <= 1'b0;
            err_r <= 1'b0;
            unique case (info.kind)
                K_START: begin
                    // a second start aborts the open packet and opens a new one
                    err_r  <= open_r;
                    open_r <= 1'b1;
                    head_r <= info.field;
                end
                K_STOP: begin
                    if (open_r) begin
                        pay_r  <= place_half(place_half('0, head_r, 0), info.field, HALF_BYTES);
                        val_r  <= 1'b1;
                        open_r <= 1'b0;
                    end else begin
                        err_r <= 1'b1;
                    end
                end
                K_BAD: begin
                    err_r  <= 1'b1;
                    open_r <= 1'b0;
                end
                default: begin
                    // data words and other control blocks are passed over
                end
            endcase
        end
    end

endmodule

// File: rtl/ctl_pkt_framer.sv
module ctl_pkt_framer
    import cpf_pkg::*;
#(
    parameter int unsigned MIN_GAP = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [111:0]   in_payload,
    output logic [65:0]    tx_word,
    input  logic [65:0]    rx_word,
    output logic           out_valid,
    output logic [111:0]   out_payload,
    output logic           rx_err
);

    word_info_t rx_info;

    cpf_tx #(.MIN_GAP(MIN_GAP)) i_tx (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_payload (in_payload),
        .tx_word    (tx_word)
    );

    cpf_classify i_cls (
        .word (rx_word),
        .info (rx_info)
    );

    cpf_rx i_rx (
        .clk         (clk),
        .rst         (rst),
        .info        (rx_info),
        .out_valid   (out_valid),
        .out_payload (out_payload),
        .rx_err      (rx_err)
    );

endmodule

// File: rtl/cpf_checker.sv
module cpf_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [9:0] tx_head,
    input logic [1:0] rx_sync,
    input logic       out_valid,
    input logic       rx_err
);

    logic accept;
    assign accept = in_valid && in_ready;

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> tx_head == {2'b10, 8'h78}); // R3

    AST_NO_START_UNASKED: assert property (@(posedge clk) disable iff (rst)
        !accept |=> tx_head != {2'b10, 8'h78}); // R2

    AST_STOP_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        tx_head == {2'b10, 8'h78} |=> tx_head == {2'b10, 8'hFF}); // R4

    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        tx_head == {2'b10, 8'hFF} |=> tx_head == {2'b10, 8'h1E}); // R5

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready); // R6

    AST_BAD_SYNC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rx_sync == 2'b00 || rx_sync == 2'b11) |=> rx_err); // R9

    AST_ERR_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && rx_err)); // R10

endmodule

bind ctl_pkt_framer cpf_checker i_cpf_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_head   (tx_word[65:56]),
    .rx_sync   (rx_word[65:64]),
    .out_valid (out_valid),
    .rx_err    (rx_err)
);

// File: tb/test_ctl_pkt_framer.sv
module test_ctl_pkt_framer;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [111:0] in_payload;
    logic [65:0]  tx_word;
    logic [65:0]  rx_word;
    logic         out_valid;
    logic [111:0] out_payload;
    logic         rx_err;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ctl_pkt_framer i_ctl_pkt_framer (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_payload  (in_payload),
        .tx_word     (tx_word),
        .rx_word     (rx_word),
        .out_valid   (out_valid),
        .out_payload (out_payload),
        .rx_err      (rx_err)
    );

    localparam logic [111:0] PAY_P = 112'h0E0D0C0B0A090807060504030201;
    localparam logic [111:0] PAY_Q = 112'h1E1D1C1B1A191817161514131211;
    localparam logic [65:0] W_IDLE  = {2'b10, 8'h1E, 56'h0};
    localparam logic [65:0] W_START = {2'b10, 8'h78, 56'h01020304050607};
    localparam logic [65:0] W_STOP  = {2'b10, 8'hFF, 56'h08090A0B0C0D0E};
    localparam logic [65:0] Q_START = {2'b10, 8'h78, 56'h11121314151617};
    localparam logic [65:0] Q_STOP  = {2'b10, 8'hFF, 56'h18191A1B1C1D1E};
    localparam logic [65:0] W_DATA  = {2'b01, 64'hDEADBEEF00C0FFEE};
    localparam logic [65:0] W_OTHER = {2'b10, 8'h2D, 56'h55555555555555};
    localparam logic [65:0] W_BAD0  = {2'b00, 8'h78, 56'h0};
    localparam logic [65:0] W_BAD3  = {2'b11, 8'hFF, 56'h0};

    localparam int NV = 18;
    // {word, expected out_valid, expected rx_err} on the clock after the word
    localparam logic [67:0] RXV [NV] = '{
        {W_IDLE,  2'b00},   // R12
        {W_DATA,  2'b00},   // R12
        {W_START, 2'b00},   // R7
        {W_STOP,  2'b10},   // R7
        {W_STOP,  2'b01},   // R10
        {W_START, 2'b00},   // R8
        {W_DATA,  2'b00},   // R8
        {W_OTHER, 2'b00},   // R8
        {W_STOP,  2'b10},   // R8
        {W_START, 2'b00},   // R11
        {W_START, 2'b01},   // R11
        {W_STOP,  2'b10},   // R11
        {W_START, 2'b00},   // R9
        {W_BAD0,  2'b01},   // R9
        {W_STOP,  2'b01},   // R9
        {W_BAD3,  2'b01},   // R9
        {W_IDLE,  2'b00},   // R12
        {W_DATA,  2'b00}    // R12
    };
    localparam string RXTAG [NV] = '{
        "R12", "R12", "R7", "R7", "R10", "R8", "R8", "R8", "R8",
        "R11", "R11", "R11", "R9", "R9", "R9", "R9", "R12", "R12"
    };

    task automatic check(input bit ok, input string tag, input logic [111:0] act,
                         input logic [111:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : main
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_payload = '0;
        rx_word    = W_IDLE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(tx_word == W_IDLE, "R1 tx_word", 112'(tx_word), 112'(W_IDLE));
        check(in_ready == 1'b1, "R1 in_ready", 112'(in_ready), 112'd1);
        check(out_valid == 1'b0, "R1 out_valid", 112'(out_valid), 112'd0);
        check(rx_err == 1'b0, "R1 rx_err", 112'(rx_err), 112'd0);

        // R2 idle fill without a request
        for (int i = 0; i < 3; i++) begin
            step();
            check(tx_word == W_IDLE, "R2 idle fill", 112'(tx_word), 112'(W_IDLE));
        end

        // receive table walk
        for (int i = 0; i < NV; i++) begin
            rx_word = RXV[i][67:2];
            step();
            check(out_valid == RXV[i][1], {RXTAG[i], " out_valid"},
                  112'(out_valid), 112'(RXV[i][1]));
            check(rx_err == RXV[i][0], {RXTAG[i], " rx_err"},
                  112'(rx_err), 112'(RXV[i][0]));
            if (RXV[i][1]) begin
                check(out_payload == PAY_P, {RXTAG[i], " payload"}, out_payload, PAY_P);
            end
        end
        rx_word = W_IDLE;

        // transmit: accept P, then keep requesting with Q
        in_valid   = 1'b1;
        in_payload = PAY_P;
        step();
        check(tx_word == W_START, "R3 start word", 112'(tx_word), 112'(W_START));
        check(in_ready == 1'b0, "R6 busy after accept", 112'(in_ready), 112'd0);
        in_payload = PAY_Q;  // must not disturb the stop word (R4)
        step();
        check(tx_word == W_STOP, "R4 stop word held bytes", 112'(tx_word), 112'(W_STOP));
        check(in_ready == 1'b0, "R6 busy during stop", 112'(in_ready), 112'd0);
        step();
        check(tx_word == W_IDLE, "R5 idle after stop", 112'(tx_word), 112'(W_IDLE));
        check(in_ready == 1'b1, "R6 ready after gap", 112'(in_ready), 112'd1);
        step();
        check(tx_word == Q_START, "R5 back-to-back start", 112'(tx_word), 112'(Q_START));
        in_valid = 1'b0;
        step();
        check(tx_word == Q_STOP, "R4 second stop word", 112'(tx_word), 112'(Q_STOP));
        step();
        check(tx_word == W_IDLE, "R5 idle after second stop", 112'(tx_word), 112'(W_IDLE));
        step();
        check(tx_word == W_IDLE, "R2 idle with no request", 112'(tx_word), 112'(W_IDLE));

        // loop the Q packet back through the receiver (R7)
        rx_word = Q_START;
        step();
        rx_word = Q_STOP;
        step();
        check(out_valid == 1'b1, "R7 loopback valid", 112'(out_valid), 112'd1);
        check(out_payload == PAY_Q, "R7 loopback payload", out_payload, PAY_Q);
        rx_word = W_IDLE;
        step();
        check(out_valid == 1'b0, "R7 single-cycle strobe", 112'(out_valid), 112'd0);

        // reset mid-packet returns to idle (R1)
        in_valid   = 1'b1;
        in_payload = PAY_P;
        step();
        in_valid = 1'b0;
        rst      = 1'b1;
        step();
        rst = 1'b0;
        check(tx_word == W_IDLE, "R1 reset mid-packet", 112'(tx_word), 112'(W_IDLE));
        check(in_ready == 1'b1, "R1 ready after reset", 112'(in_ready), 112'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule